// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Tagged Queue

This block turns an asynchronous serial line into parallel characters. A sample enable that pulses 16 times per bit period drives a receive state machine. The machine checks each start bit at mid-bit and samples every data, parity and stop bit at its centre. Each finished character is stored together with three flags: parity error, framing error and break. The flags stay with the character they describe until software reads it.

Two storage modes are available. In character mode there is a single holding slot, and a new character replaces an unread one. In queue mode there is a first-in first-out buffer with 16 entries, and a new character that finds the buffer full is dropped. In both modes that case raises an overrun pulse. In queue mode an idle timer raises a character-timeout indication when unread data has been waiting too long. A transfer-ready output tells a DMA engine when to empty the queue.

The head entry is always present on the pop outputs. The consumer reads it while `data_avail` is high and pulses `pop` to take it out.

Top module: `serial_rx_queue`

## Requirements
- R1: One bit period is 16 sample enables. Data arrives least significant bit first. `word_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `pop_data` read 0.
- R2: When `parity_en` is 1, a parity bit follows the data. `parity_even` = 1 selects even parity and 0 selects odd parity. `pop_parity_err` is 1 when the received bit does not match.
- R3: A stop bit sampled low sets `pop_frame_err` on a character that is not a break. The receiver then waits for the line to go high before it looks for a new start bit.
- R4: If the line is high again at the mid-bit check of the start bit, the start bit is rejected. No character is produced and the receiver hunts for a new start edge.
- R5: A break is a frame in which the data bits, the parity bit and the stop bit are all low. It is stored as exactly one entry with data 0, `pop_break` = 1 and both other flags 0. No further character is accepted until the line returns high.
- R6: When `fifo_mode` is 1, up to 16 entries are stored and returned in arrival order. Each entry keeps its own flags.
- R7: When a character completes and storage is full without a pop in the same cycle, `overrun` pulses for one cycle. In queue mode the new character is discarded. In character mode it replaces the held character.
- R8: When `fifo_mode` is 0, a single character is held. `data_avail` is 1 exactly while storage is not empty.
- R9: In queue mode, `char_timeout` rises after the queue has been non-empty for 4 frame times with no character stored and none popped. A pop clears it. It never rises in character mode.
- R10: In character mode `dma_ready` equals `data_avail`. In queue mode it is 1 when at least 8 entries are stored or `char_timeout` is 1.
- R11: Any change of `fifo_mode` empties the storage.
- R12: A `pop` while storage is empty has no effect.
- R13: After reset `data_avail`, `char_timeout`, `overrun` and `dma_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | Sample enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| fifo_mode | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding slot |
| word_len | input | 2 | Number of data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 for even parity, 0 for odd parity |
| pop | input | 1 | Remove the head entry |
| pop_data | output | 8 | Head entry data |
| pop_parity_err | output | 1 | Head entry parity error flag |
| pop_frame_err | output | 1 | Head entry framing error flag |
| pop_break | output | 1 | Head entry break flag |
| data_avail | output | 1 | Storage not empty |
| char_timeout | output | 1 | Unread data has been idle too long |
| overrun | output | 1 | One-cycle pulse when a character meets full storage |
| dma_ready | output | 1 | Transfer request for a DMA engine |

## Verification
The hardest state to reach is a full queue that holds entries with mixed flags, followed by one more character. The stimulus sends 16 frames back to back with automatic draining switched off. Some of these frames carry a deliberately wrong parity bit and some a low stop bit. The transfer-ready threshold is checked between the seventh and the eighth frame. A seventeenth frame must then produce a single overrun pulse and must never appear when the queue is drained. A line held low for far longer than a frame checks that a break produces exactly one entry. Long waits with unread data check the timeout window on both sides of the limit.

// File: rtl/srq_pkg.sv
package srq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_t;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  // number of data bits for a word length code
  function automatic int unsigned data_bits(input logic [1:0] wl);
    return 5 + int'(wl);
  endfunction

  // samples in one frame: start + data + optional parity + stop
  function automatic int unsigned frame_ticks(input logic [1:0] wl, input logic pen,
                                              input int unsigned os);
    return (2 + data_bits(wl) + int'(pen)) * os;
  endfunction

  // shift register fills from the top; move the word down to bit 0
  function automatic logic [7:0] right_align(input logic [7:0] sh, input logic [1:0] wl);
    return sh >> (2'd3 - wl);
  endfunction

  // 1 when data plus parity bit do not meet the selected sense
  function automatic logic parity_fault(input logic [7:0] d, input logic pbit, input logic even);
    return (^d) ^ pbit ^ ~even;
  endfunction

endpackage

// File: rtl/srq_sampler.sv
module srq_sampler
  import srq_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_line,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  output logic       char_valid,
  output rx_entry_t  char_out
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);

  logic            rx_meta, rx_s;
  rx_state_t       state;
  logic [CW-1:0]   cnt;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic            pbit;
  logic [2:0]      last_bit;
  logic [7:0]      word;
  logic            is_break;

  assign last_bit = 3'd4 + {1'b0, word_len};
  assign word     = right_align(shreg, word_len);
  assign is_break = (word == 8'd0) && !pbit && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_line;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          S_IDLE: if (!rx_s) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt     <= '0;
            bit_idx <= '0;
            pbit    <= 1'b0;
            state   <= rx_s ? S_IDLE : S_DATA;  // high at mid-bit: spurious start
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bit_idx == last_bit) state <= parity_en ? S_PAR : S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == LAST) begin
            cnt   <= '0;
            pbit  <= rx_s;
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == LAST) begin
            cnt        <= '0;
            char_valid <= 1'b1;
            if (is_break) char_out <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: 8'd0};
            else char_out <= '{brk: 1'b0, ferr: !rx_s,
                               perr: parity_en && parity_fault(word, pbit, parity_even),
                               data: word};
            state <= rx_s ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
          S_HOLD: if (rx_s) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/srq_store.sv
module srq_store
  import srq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             push,
  input  rx_entry_t        push_entry,
  input  logic             pop,
  output rx_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             do_pop,
  output logic             overrun
);

  localparam int PTR_W = $clog2(DEPTH);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             mode_q;
  logic             flush, take, clobber;

  assign flush   = mode_q != fifo_mode;
  assign empty   = count == '0;
  assign full    = fifo_mode ? (count == CNT_W'(DEPTH)) : !empty;
  assign do_pop  = pop && !empty;
  assign take    = push && (!full || do_pop);
  assign clobber = push && full && !do_pop && !fifo_mode;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= push_entry;
    else if (clobber) mem[rd_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
      if (flush) begin
        rd_ptr  <= '0;
        wr_ptr  <= '0;
        count   <= '0;
        overrun <= 1'b0;
      end else begin
        if (take)   wr_ptr <= wr_ptr + 1'b1;
        if (do_pop) rd_ptr <= rd_ptr + 1'b1;
        count   <= count + CNT_W'(take) - CNT_W'(do_pop);
        overrun <= push && full && !do_pop;
      end
    end
  end

endmodule

// File: rtl/srq_idle_timer.sv
module srq_idle_timer #(
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             restart,
  input  logic [TMR_W-1:0] limit,
  output logic             timeout
);

  logic [TMR_W-1:0] cnt;

  assign timeout = cnt >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!active || restart) cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int OVERSAMPLE    = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int TRIG_LEVEL    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rx_line,
  input  logic       fifo_mode,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic       pop_parity_err,
  output logic       pop_frame_err,
  output logic       pop_break,
  output logic       data_avail,
  output logic       char_timeout,
  output logic       overrun,
  output logic       dma_ready
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CHARS * 11 * OVERSAMPLE + 1);

  // internal events brought out for the checker
  logic             char_push;
  rx_entry_t        char_entry;
  rx_entry_t        head;
  logic [CNT_W-1:0] store_count;
  logic             store_full, store_empty, store_pop;
  logic [TMR_W-1:0] to_limit;

  srq_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rx_line(rx_line),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .char_valid(char_push), .char_out(char_entry)
  );

  srq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .push(char_push), .push_entry(char_entry), .pop(pop),
    .head(head), .count(store_count), .full(store_full), .empty(store_empty),
    .do_pop(store_pop), .overrun(overrun)
  );

  assign to_limit = TMR_W'(TIMEOUT_CHARS * frame_ticks(word_len, parity_en, OVERSAMPLE));

  srq_idle_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x),
    .active(fifo_mode && !store_empty), .restart(char_push || store_pop),
    .limit(to_limit), .timeout(char_timeout)
  );

  assign pop_data       = head.data;
  assign pop_parity_err = head.perr;
  assign pop_frame_err  = head.ferr;
  assign pop_break      = head.brk;
  assign data_avail     = !store_empty;
  assign dma_ready      = fifo_mode ? ((store_count >= CNT_W'(TRIG_LEVEL)) || char_timeout)
                                    : !store_empty;

endmodule

// File: rtl/srq_checker.sv
module srq_checker
  import srq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             data_avail,
  input logic             char_timeout,
  input logic             overrun,
  input logic             store_full,
  input logic [CNT_W-1:0] store_count,
  input logic             char_push,
  input rx_entry_t        char_entry
);

  assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |-> store_count <= CNT_W'(DEPTH));

  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && $stable(fifo_mode)) |-> store_count <= CNT_W'(1));

  assert_timeout_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    char_timeout |-> data_avail);

  assert_no_timeout_char_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && $past(!fifo_mode)) |-> !char_timeout);

  assert_overrun_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(store_full));

  assert_break_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_push && char_entry.brk) |-> (char_entry.data == 8'd0 && !char_entry.perr && !char_entry.ferr));

endmodule

bind serial_rx_queue srq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_srq_checker (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .data_avail(data_avail),
  .char_timeout(char_timeout), .overrun(overrun), .store_full(store_full),
  .store_count(store_count), .char_push(char_push), .char_entry(char_entry)
);

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;

  localparam int BIT_CLK = 32;  // 16 sample enables, one every second clock

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       fifo_mode = 1'b0;
  logic [1:0] wl = 2'd3;
  logic       pen = 1'b0;
  logic       pev = 1'b0;
  logic       pop;
  logic [7:0] pop_data;
  logic       pop_perr, pop_ferr, pop_brk;
  logic       data_avail, char_timeout, overrun, dma_ready;

  int checks = 0;
  int errors = 0;
  int ovr_cnt = 0;
  bit auto_pop = 1'b0;
  bit man_req = 1'b0;
  logic [10:0] exp_q [$];  // {brk, ferr, perr, data}

  always #2.5 clk = ~clk;

  serial_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rx_line(rx), .fifo_mode(fifo_mode),
    .word_len(wl), .parity_en(pen), .parity_even(pev), .pop(pop),
    .pop_data(pop_data), .pop_parity_err(pop_perr), .pop_frame_err(pop_ferr),
    .pop_break(pop_brk), .data_avail(data_avail), .char_timeout(char_timeout),
    .overrun(overrun), .dma_ready(dma_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (overrun) ovr_cnt++;
    end
  end

  // monitor: pops and compares against the scoreboard
  initial begin
    pop = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_pop && data_avail) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected entry", {21'd0, pop_brk, pop_ferr, pop_perr, pop_data}, 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check({pop_brk, pop_ferr, pop_perr, pop_data} == e, "R1/R2/R3/R6 entry",
                {21'd0, pop_brk, pop_ferr, pop_perr, pop_data}, {21'd0, e});
        end
        pop = 1'b1;
      end else if (man_req) begin
        pop = 1'b1;
        man_req = 1'b0;
      end else pop = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bit(input logic v);
    @(negedge clk);
    rx = v;
    repeat (BIT_CLK - 1) @(negedge clk);
  endtask

  task automatic man_pop();
    man_req = 1'b1;
    while (man_req) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: sends one frame with the current config, queues the expected entry
  // pmode: 0 no parity bit, 1 correct parity bit, 2 inverted parity bit
  task automatic send(input logic [7:0] data, input int pmode, input logic stop, input bit expect_it);
    int nb;
    logic [7:0] d;
    logic pb;
    nb = 5 + int'(wl);
    d = data & ((8'd1 << nb) - 8'd1);
    pb = pev ? ^d : ~^d;
    if (pmode == 2) pb = ~pb;
    if (expect_it) exp_q.push_back({1'b0, !stop, pmode == 2, d});
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (pmode != 0) line_bit(pb);
    line_bit(stop);
    if (!stop) line_bit(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int o0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R13 reset state
    check(data_avail == 0, "R13 data_avail", data_avail, 0);
    check(char_timeout == 0, "R13 char_timeout", char_timeout, 0);
    check(overrun == 0, "R13 overrun", overrun, 0);
    check(dma_ready == 0, "R13 dma_ready", dma_ready, 0);

    // R1 R2 R3 R8: character mode, several formats
    auto_pop = 1'b1;
    wl = 2'd3; pen = 0; send(8'hA5, 0, 1, 1); send(8'h3C, 0, 1, 1);
    wl = 2'd2; pen = 1; pev = 1; send(8'h55, 1, 1, 1);
    wl = 2'd1; pen = 1; pev = 0; send(8'h2A, 1, 1, 1);
    wl = 2'd0; pen = 0; send(8'hF3, 0, 1, 1);
    wl = 2'd3; pen = 1; pev = 1; send(8'h81, 2, 1, 1);
    pev = 0; send(8'h6E, 1, 1, 1); send(8'h07, 2, 1, 1);
    pen = 0; send(8'h7E, 0, 0, 1);  // R3 framing error
    idle(20);
    check(exp_q.size() == 0, "R1 all characters received", exp_q.size(), 0);

    // R4 false start
    auto_pop = 1'b0;
    @(negedge clk); rx = 1'b0; idle(8); rx = 1'b1; idle(3 * BIT_CLK);
    check(data_avail == 0, "R4 no character from short pulse", data_avail, 0);
    auto_pop = 1'b1;
    send(8'h5A, 0, 1, 1); idle(20);
    check(exp_q.size() == 0, "R4 recovery after false start", exp_q.size(), 0);

    // R5 break
    auto_pop = 1'b0;
    @(negedge clk); rx = 1'b0; idle(20 * BIT_CLK);
    check(data_avail == 1, "R5 break stored", data_avail, 1);
    check({pop_brk, pop_ferr, pop_perr, pop_data} == 11'h400, "R5 break entry",
          {pop_brk, pop_ferr, pop_perr, pop_data}, 11'h400);
    man_pop();
    check(data_avail == 0, "R5 single break entry", data_avail, 0);
    rx = 1'b1; idle(2 * BIT_CLK);
    auto_pop = 1'b1;
    send(8'hC3, 0, 1, 1); idle(20);
    check(exp_q.size() == 0, "R5 reception after break", exp_q.size(), 0);

    // R7 character mode overrun replaces held character
    auto_pop = 1'b0;
    o0 = ovr_cnt;
    send(8'h11, 0, 1, 0); send(8'h22, 0, 1, 0); idle(4);
    check(ovr_cnt == o0 + 1, "R7 overrun pulse character mode", ovr_cnt - o0, 1);
    check(pop_data == 8'h22, "R7 held character replaced", pop_data, 8'h22);
    check(dma_ready == 1, "R10 dma_ready follows data_avail", dma_ready, 1);
    man_pop();
    check(data_avail == 0, "R8 holding slot emptied", data_avail, 0);

    // R12 pop on empty
    man_pop();
    check(data_avail == 0, "R12 pop on empty", data_avail, 0);
    send(8'h44, 0, 1, 0); idle(4);
    check(pop_data == 8'h44, "R12 next character intact", pop_data, 8'h44);
    // R9 no timeout in character mode
    idle(6 * 10 * BIT_CLK);
    check(char_timeout == 0, "R9 no timeout in character mode", char_timeout, 0);
    man_pop();
    check(data_avail == 0, "R12 one entry only", data_avail, 0);

    // R6 R10 R7 queue mode fill
    fifo_mode = 1'b1; idle(4);
    pen = 1; pev = 1;
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 17 + 3), (i % 5 == 2) ? 2 : 1, (i % 7 == 4) ? 1'b0 : 1'b1, 1);
      if (i == 6) check(dma_ready == 0, "R10 below threshold", dma_ready, 0);
      if (i == 7) check(dma_ready == 1, "R10 at threshold", dma_ready, 1);
    end
    o0 = ovr_cnt;
    send(8'hEE, 1, 1, 0); idle(4);
    check(ovr_cnt == o0 + 1, "R7 overrun pulse queue mode", ovr_cnt - o0, 1);
    auto_pop = 1'b1; idle(60);
    check(exp_q.size() == 0, "R6 all 16 entries in order", exp_q.size(), 0);
    check(data_avail == 0, "R7 dropped character absent", data_avail, 0);

    // R9 R10 timeout
    auto_pop = 1'b0;
    send(8'h99, 1, 1, 1);
    idle(2 * 11 * BIT_CLK);
    check(char_timeout == 0, "R9 timeout not before limit", char_timeout, 0);
    check(dma_ready == 0, "R10 one entry no request", dma_ready, 0);
    idle(5 * 11 * BIT_CLK);
    check(char_timeout == 1, "R9 timeout after 4 frames", char_timeout, 1);
    check(dma_ready == 1, "R10 request on timeout", dma_ready, 1);
    auto_pop = 1'b1; idle(10);
    check(char_timeout == 0, "R9 cleared by pop", char_timeout, 0);

    // R11 mode change flush
    auto_pop = 1'b0;
    send(8'h12, 1, 1, 0); send(8'h34, 1, 1, 0); idle(4);
    check(data_avail == 1, "R11 entries before switch", data_avail, 1);
    @(negedge clk); fifo_mode = 1'b0; idle(3);
    check(data_avail == 0, "R11 flush on mode change", data_avail, 0);

    idle(10);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule